// File: doc/BRIEF.md
# Masked Interrupt Combiner with Sync-Event Capture

This block merges four internal interrupt causes into one level-high interrupt line for a command-driven serial engine. Three causes track buffer watermarks: the command buffer running low, the serial-out buffer running low, and the serial-in buffer filling up. They follow the buffer levels and clear themselves when the level moves back across its watermark. The fourth cause is sticky. It is raised when a synchronization token arrives on an always-ready token stream, and the token's ID is latched into a readable register at the same time.

Software sets a mask word. The block shows the raw cause word, the masked (pending) word and the latched ID. Software acknowledges the sticky cause by writing 1 to its bit in the pending word. The buffer logic supplies the level and watermark inputs. The bus wrapper lies outside this block and drives a simple one-cycle write strobe with a register select.

Top module: `irq_gather`

## Requirements
- R1: While `rstN` is low at a clock edge, the raw word, the mask and the latched ID go to zero, and `irqOut` is low from the following edge.
- R2: Bit order in the raw, mask and pending words is: bit 0 command low, bit 1 serial-out low, bit 2 serial-in high, bit 3 sync event. `pendingOut` equals `rawOut & maskOut`.
- R3: `irqOut` is high exactly when some pending bit is set. A masked cause does not drive `irqOut`, but its raw bit stays visible on `rawOut`.
- R4: Raw bits 0 and 1 are set from the edge after their level is strictly below their watermark. They clear from the edge after the level is equal to or above it.
- R5: Raw bit 2 is set from the edge after the serial-in level is strictly above its watermark. It clears from the edge after the level is equal to or below it.
- R6: An edge with `syncValid` high sets raw bit 3 and stores `syncId` into `syncIdOut`.
- R7: A write with `regWrSel`=1 (the pending word) and data bit 3 = 1 clears raw bit 3 at that edge. If data bit 3 is 0, the write has no effect. Pending-word writes never change raw bits 0 to 2.
- R8: If a token and an acknowledge arrive at the same edge, raw bit 3 stays set and the new ID is stored.
- R9: A write with `regWrSel`=0 loads `regWrData` into the mask at that edge. `syncReady` is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rstN | input | 1 | Synchronous active-low reset |
| cmdLevel | input | LVL_W | Command buffer fill level |
| cmdMark | input | LVL_W | Command low watermark |
| sdoLevel | input | LVL_W | Serial-out buffer fill level |
| sdoMark | input | LVL_W | Serial-out low watermark |
| sdiLevel | input | LVL_W | Serial-in buffer fill level |
| sdiMark | input | LVL_W | Serial-in high watermark |
| syncValid | input | 1 | Sync token present |
| syncId | input | ID_W | ID carried by the token |
| syncReady | output | 1 | Token accept, tied high |
| regWrEn | input | 1 | One-cycle register write strobe |
| regWrSel | input | 1 | 0 = mask word, 1 = pending word (acknowledge) |
| regWrData | input | 4 | Write data |
| maskOut | output | 4 | Mask word |
| rawOut | output | 4 | Raw cause word |
| pendingOut | output | 4 | Masked cause word |
| syncIdOut | output | ID_W | Last latched token ID |
| irqOut | output | 1 | Level-high interrupt |

## Verification
Every result is due one clock edge after its stimulus. Raw watermark bits, the mask, the sticky bit and the ID are all registered. The pending word and `irqOut` are combinational views of those registers, so they change in the same cycle as the registers they depend on. The bench drives inputs on the falling edge, lets exactly one rising edge pass, and samples one nanosecond later. Each checked value is therefore the result of a single edge. Strobes are dropped before the next edge, so the no-effect and same-edge collision cases show up at the ports in the cycle they occur.

// File: rtl/irq_gather_pkg.sv
package irq_gather_pkg;
  localparam int NUM_SRC  = 4;
  localparam int NUM_WM   = 3;
  localparam int SRC_CMD  = 0;
  localparam int SRC_SDO  = 1;
  localparam int SRC_SDI  = 2;
  localparam int SRC_SYNC = 3;

  typedef struct packed {
    logic loadMask;
    logic ackSync;
    logic captureSync;
  } strobe_t;
endpackage

// File: rtl/irq_gather_ctrl.sv
module irq_gather_ctrl
  import irq_gather_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    regWrEn,
  input  logic    regWrSel,
  input  logic    ackBit,
  input  logic    syncValid,
  output logic    syncReady,
  output strobe_t strobe
);
  always_comb begin
    strobe.loadMask    = regWrEn & ~regWrSel;
    strobe.ackSync     = regWrEn & regWrSel & ackBit;
    strobe.captureSync = syncValid;
  end

  assign syncReady = 1'b1;

  // Mask load and acknowledge come from different selects, so they never occur together.
  AST_SEL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.loadMask && strobe.ackSync)); // R9
  AST_ACK_NEEDS_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regWrSel && !ackBit) |-> !strobe.ackSync); // R7
endmodule

// File: rtl/irq_gather_dp.sv
module irq_gather_dp
  import irq_gather_pkg::*;
#(
  parameter int LVL_W = 5,
  parameter int ID_W  = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  strobe_t                        strobe,
  input  logic [NUM_WM-1:0][LVL_W-1:0]   levels,
  input  logic [NUM_WM-1:0][LVL_W-1:0]   marks,
  input  logic [NUM_SRC-1:0]             wrData,
  input  logic [ID_W-1:0]                syncIdIn,
  output logic [NUM_SRC-1:0]             rawQ,
  output logic [NUM_SRC-1:0]             maskQ,
  output logic [NUM_SRC-1:0]             pending,
  output logic [ID_W-1:0]                syncIdQ,
  output logic                           irq
);
  logic [NUM_WM-1:0] wmNext;
  logic [NUM_WM-1:0] wmQ;
  logic              syncFlag;

  for (genvar g = 0; g < NUM_WM; g++) begin : g_wm
    if (g == SRC_SDI) begin : g_above
      assign wmNext[g] = levels[g] > marks[g];
    end else begin : g_below
      assign wmNext[g] = levels[g] < marks[g];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wmQ      <= '0;
      maskQ    <= '0;
      syncFlag <= 1'b0;
      syncIdQ  <= '0;
    end else begin
      wmQ <= wmNext;
      if (strobe.loadMask) maskQ <= wrData;
      if (strobe.captureSync) begin
        syncFlag <= 1'b1;
        syncIdQ  <= syncIdIn;
      end else if (strobe.ackSync) begin
        syncFlag <= 1'b0;
      end
    end
  end

  assign rawQ    = {syncFlag, wmQ};
  assign pending = rawQ & maskQ;
  assign irq     = |pending;

  AST_SYNC_SETS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.captureSync |=> rawQ[SRC_SYNC]); // R6
  AST_SYNC_ID: assert property (@(posedge clk) disable iff (!rstN)
    strobe.captureSync |=> syncIdQ == $past(syncIdIn)); // R6
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ackSync && !strobe.captureSync) |=> !rawQ[SRC_SYNC]); // R7
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (rawQ[SRC_SYNC] && !strobe.ackSync) |=> rawQ[SRC_SYNC]); // R8
  AST_MASK_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadMask |=> $stable(maskQ)); // R9
  AST_CMD_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (levels[SRC_CMD] < marks[SRC_CMD]) |=> rawQ[SRC_CMD]); // R4
  AST_SDI_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (levels[SRC_SDI] <= marks[SRC_SDI]) |=> !rawQ[SRC_SDI]); // R5
  AST_NO_MASK_NO_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ == '0) |-> !irq); // R3
endmodule

// File: rtl/irq_gather.sv
module irq_gather
  import irq_gather_pkg::*;
#(
  parameter int LVL_W = 5,
  parameter int ID_W  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LVL_W-1:0] cmdLevel,
  input  logic [LVL_W-1:0] cmdMark,
  input  logic [LVL_W-1:0] sdoLevel,
  input  logic [LVL_W-1:0] sdoMark,
  input  logic [LVL_W-1:0] sdiLevel,
  input  logic [LVL_W-1:0] sdiMark,
  input  logic             syncValid,
  input  logic [ID_W-1:0]  syncId,
  output logic             syncReady,
  input  logic             regWrEn,
  input  logic             regWrSel,
  input  logic [3:0]       regWrData,
  output logic [3:0]       maskOut,
  output logic [3:0]       rawOut,
  output logic [3:0]       pendingOut,
  output logic [ID_W-1:0]  syncIdOut,
  output logic             irqOut
);
  strobe_t                      strobe;
  logic [NUM_WM-1:0][LVL_W-1:0] levels;
  logic [NUM_WM-1:0][LVL_W-1:0] marks;

  assign levels[SRC_CMD] = cmdLevel;
  assign levels[SRC_SDO] = sdoLevel;
  assign levels[SRC_SDI] = sdiLevel;
  assign marks[SRC_CMD]  = cmdMark;
  assign marks[SRC_SDO]  = sdoMark;
  assign marks[SRC_SDI]  = sdiMark;

  irq_gather_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regWrSel  (regWrSel),
    .ackBit    (regWrData[SRC_SYNC]),
    .syncValid (syncValid),
    .syncReady (syncReady),
    .strobe    (strobe)
  );

  irq_gather_dp #(.LVL_W(LVL_W), .ID_W(ID_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .levels   (levels),
    .marks    (marks),
    .wrData   (regWrData),
    .syncIdIn (syncId),
    .rawQ     (rawOut),
    .maskQ    (maskOut),
    .pending  (pendingOut),
    .syncIdQ  (syncIdOut),
    .irq      (irqOut)
  );
endmodule

// File: tb/tb_irq_gather.sv
`timescale 1ns/1ps
module tb_irq_gather;
  localparam int LVL_W = 5;
  localparam int ID_W  = 8;
  localparam int NVEC  = 8;

  logic             clk = 1'b0;
  logic             rstN;
  logic [LVL_W-1:0] cmdLevel, cmdMark, sdoLevel, sdoMark, sdiLevel, sdiMark;
  logic             syncValid;
  logic [ID_W-1:0]  syncId;
  logic             syncReady;
  logic             regWrEn, regWrSel;
  logic [3:0]       regWrData;
  logic [3:0]       maskOut, rawOut, pendingOut;
  logic [ID_W-1:0]  syncIdOut;
  logic             irqOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  irq_gather #(.LVL_W(LVL_W), .ID_W(ID_W)) dut (
    .clk(clk), .rstN(rstN),
    .cmdLevel(cmdLevel), .cmdMark(cmdMark),
    .sdoLevel(sdoLevel), .sdoMark(sdoMark),
    .sdiLevel(sdiLevel), .sdiMark(sdiMark),
    .syncValid(syncValid), .syncId(syncId), .syncReady(syncReady),
    .regWrEn(regWrEn), .regWrSel(regWrSel), .regWrData(regWrData),
    .maskOut(maskOut), .rawOut(rawOut), .pendingOut(pendingOut),
    .syncIdOut(syncIdOut), .irqOut(irqOut)
  );

  // {cmdL, cmdM, sdoL, sdoM, sdiL, sdiM, mask, expRaw[2:0], expIrq}
  typedef struct packed {
    logic [4:0] cl, cm, ol, om, il, im;
    logic [3:0] mask;
    logic [2:0] raw;
    logic       irq;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{5'd2, 5'd4, 5'd8, 5'd4, 5'd3,  5'd10, 4'hF, 3'b001, 1'b1},
    '{5'd4, 5'd4, 5'd3, 5'd4, 5'd11, 5'd10, 4'h0, 3'b110, 1'b0},
    '{5'd4, 5'd4, 5'd3, 5'd4, 5'd11, 5'd10, 4'h4, 3'b110, 1'b1},
    '{5'd5, 5'd4, 5'd4, 5'd4, 5'd10, 5'd10, 4'hF, 3'b000, 1'b0},
    '{5'd0, 5'd1, 5'd0, 5'd1, 5'd31, 5'd30, 4'h3, 3'b111, 1'b1},
    '{5'd0, 5'd0, 5'd0, 5'd0, 5'd0,  5'd0,  4'hF, 3'b000, 1'b0},
    '{5'd1, 5'd2, 5'd9, 5'd9, 5'd31, 5'd31, 4'h1, 3'b001, 1'b1},
    '{5'd3, 5'd2, 5'd1, 5'd2, 5'd20, 5'd0,  4'h1, 3'b110, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic neutral();
    cmdLevel = 5'd5; cmdMark = 5'd2;
    sdoLevel = 5'd5; sdoMark = 5'd2;
    sdiLevel = 5'd1; sdiMark = 5'd20;
  endtask

  // Apply the write/token set up by the caller at a falling edge, pass one rising edge, sample.
  task automatic edgeThenSample();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    @(negedge clk);
    regWrEn = 1'b0; syncValid = 1'b0;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; syncValid = 1'b0; syncId = '0;
    regWrEn = 1'b0; regWrSel = 1'b0; regWrData = '0;
    cmdLevel = 5'd0; cmdMark = 5'd4;
    sdoLevel = 5'd0; sdoMark = 5'd4;
    sdiLevel = 5'd31; sdiMark = 5'd1;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state even with every watermark condition true
    check("R1 raw", rawOut, 4'h0);
    check("R1 mask", maskOut, 4'h0);
    check("R1 id", syncIdOut, 8'h00);
    check("R1 irq", irqOut, 1'b0);
    @(negedge clk); rstN = 1'b1; neutral();
    edgeThenSample();

    // Table walk: R2 pending, R3 irq, R4 low marks, R5 high mark, R9 mask load
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      cmdLevel = VECS[i].cl; cmdMark = VECS[i].cm;
      sdoLevel = VECS[i].ol; sdoMark = VECS[i].om;
      sdiLevel = VECS[i].il; sdiMark = VECS[i].im;
      regWrEn = 1'b1; regWrSel = 1'b0; regWrData = VECS[i].mask;
      edgeThenSample();
      check("R4/R5 raw", rawOut, {1'b0, VECS[i].raw});
      check("R9 mask", maskOut, VECS[i].mask);
      check("R2 pending", pendingOut, {1'b0, VECS[i].raw} & VECS[i].mask);
      check("R3 irq", irqOut, VECS[i].irq);
      idle();
    end

    // R6: token sets sticky bit and latches ID
    neutral();
    regWrEn = 1'b1; regWrSel = 1'b0; regWrData = 4'h8;
    edgeThenSample();
    idle();
    syncValid = 1'b1; syncId = 8'h3C;
    edgeThenSample();
    check("R6 raw", rawOut, 4'h8);
    check("R6 id", syncIdOut, 8'h3C);
    check("R6 irq", irqOut, 1'b1);
    check("R9 ready", syncReady, 1'b1);
    idle();

    // R7: pending write with bit3 = 0 has no effect
    regWrEn = 1'b1; regWrSel = 1'b1; regWrData = 4'h7;
    edgeThenSample();
    check("R7 ack0 raw", rawOut, 4'h8);
    check("R7 ack0 mask", maskOut, 4'h8);
    idle();
    edgeThenSample();
    check("R7 sticky hold", rawOut, 4'h8);

    // R3: masking the sticky cause hides it from irq, raw still visible
    @(negedge clk);
    regWrEn = 1'b1; regWrSel = 1'b0; regWrData = 4'h0;
    edgeThenSample();
    check("R3 masked irq", irqOut, 1'b0);
    check("R3 masked raw", rawOut, 4'h8);
    idle();
    regWrEn = 1'b1; regWrSel = 1'b0; regWrData = 4'hF;
    edgeThenSample();
    idle();

    // R7: acknowledge with bit3 = 1 clears, watermark bits untouched
    cmdLevel = 5'd0; cmdMark = 5'd3;
    regWrEn = 1'b1; regWrSel = 1'b1; regWrData = 4'hF;
    edgeThenSample();
    check("R7 ack1 raw", rawOut, 4'h1);
    check("R7 ack1 irq", irqOut, 1'b1);
    idle();
    neutral();
    edgeThenSample();
    check("R4 self clear", rawOut, 4'h0);

    // R8: token and acknowledge at the same edge
    @(negedge clk);
    syncValid = 1'b1; syncId = 8'h11;
    edgeThenSample();
    idle();
    syncValid = 1'b1; syncId = 8'h22;
    regWrEn = 1'b1; regWrSel = 1'b1; regWrData = 4'h8;
    edgeThenSample();
    check("R8 raw", rawOut, 4'h8);
    check("R8 id", syncIdOut, 8'h22);
    idle();

    // R1: mid-run reset clears sticky bit, mask and ID
    rstN = 1'b0;
    edgeThenSample();
    check("R1 rerun raw", rawOut, 4'h0);
    check("R1 rerun mask", maskOut, 4'h0);
    check("R1 rerun id", syncIdOut, 8'h00);
    @(negedge clk); rstN = 1'b1;
    repeat (2) @(posedge clk);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule